// File: doc/BRIEF.md
# I2C Slave Controller with Clock Stretching

This block is a 7-bit-address I2C target. It brings SCL and SDA into the system clock domain and watches for START and STOP. It then shifts in an address byte and compares it with a fixed device address. When the address matches, it either receives data bytes or sends them. The block drives the bus only open-drain: each line output is a "pull low" enable, and the pad releases the line when the enable is 0.

A local host sees a one-byte buffer and four status flags: buffer full, overflow, direction and interrupt. Received bytes land in the buffer, and the host clears the full flag by reading. If a byte arrives while the buffer is still full, the block refuses it. When the bus master reads, the block holds SCL low after each acknowledged byte. The hold lasts until the host has written the next byte and then set the release bit. A release request made before that write is ignored.

Top module: `i2c_stretch_slave`

## Requirements
- R1: After reset both line enables are 0, the interrupt, full, overflow and direction flags are 0, and the release bit `rel` is 1.
- R2: After a START, an address byte sent MSB first is examined. It holds the 7-bit address followed by a direction bit, where 0 means master writes. If it matches `DEV_ADDR` with direction 0, the block pulls SDA low during the ninth clock. It also loads the whole address byte into the buffer, sets the full flag and copies the direction bit to `rw_flag`.
- R3: If the address does not match, the block drives neither line and raises no interrupt. It ignores all further bytes until the next START.
- R4: A data byte received while neither full nor overflow is set is acknowledged and stored in the buffer, and the full flag is set. A `buf_rd` strobe clears the full flag.
- R5: If the full flag or the overflow flag is set when a byte's eighth bit completes, the byte is not acknowledged and the buffer keeps its old value. The overflow flag is set if the buffer was full; `ovf_clr` clears it.
- R6: `irq` is set at the falling edge of the ninth SCL pulse of every accepted address byte and every data byte of the transfer. It stays set until `irq_clr`.
- R7: A matching address with direction 1 is acknowledged and sets `rw_flag`. After the ninth falling edge the block pulls SCL low and clears `rel`.
- R8: A `rel_set` strobe has no effect unless the buffer has been written since the stretch began. Once the buffer has been written, `rel_set` sets `rel` and releases SCL.
- R9: The transmitted byte equals the value written with `buf_wr` and goes out MSB first. SDA changes only while SCL is low.
- R10: If the master acknowledges a sent byte (SDA low at the ninth rising edge), the block sets `irq` and stretches SCL again after the ninth falling edge.
- R11: If the master does not acknowledge (SDA high at the ninth rising edge), the block clears `rw_flag` and the full flag and releases both lines. It ignores the bus until the next START.
- R12: A STOP (SDA rising while SCL is high) abandons any byte in progress, and the block waits for a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| buf_wr | input | 1 | Host strobe: write buffer and transmit shifter |
| buf_wdata | input | 8 | Host write data |
| buf_rd | input | 1 | Host strobe: buffer has been read, clears full flag |
| buf_rdata | output | 8 | Buffer contents |
| rel_set | input | 1 | Host strobe: release the stretched clock |
| irq_clr | input | 1 | Host strobe: clear interrupt flag |
| ovf_clr | input | 1 | Host strobe: clear overflow flag |
| irq | output | 1 | Interrupt flag |
| buf_full | output | 1 | Buffer full flag |
| ovf | output | 1 | Overflow flag |
| rw_flag | output | 1 | Direction of the current transfer, 1 = master reads |
| rel | output | 1 | Clock release bit, 0 while stretching |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h2D and addresses it with write byte 0x5A and read byte 0x5B. The rejected address 0x2C differs from the device address only in its last bit, so any compare that drops a bit or merges the direction bit into the address is exposed. Transmit data 0xC3 and 0x5A have distinct upper and lower halves, so a bit-order or shift-phase error changes the value the master reads.

// File: rtl/i2c_stretch_slave.sv
module i2c_stretch_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       buf_wr,
  input  logic [7:0] buf_wdata,
  input  logic       buf_rd,
  output logic [7:0] buf_rdata,
  input  logic       rel_set,
  input  logic       irq_clr,
  input  logic       ovf_clr,
  output logic       irq,
  output logic       buf_full,
  output logic       ovf,
  output logic       rw_flag,
  output logic       rel
);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_RX, S_TX} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [3:0] bitcnt;
  logic [7:0] sr, tsr, buf_q;
  logic       ack_drv, stretch, wr_done;

  wire scl_s     = scl_sy[1];
  wire sda_s     = sda_sy[1];
  wire scl_rise  = scl_s & ~scl_d;
  wire scl_fall  = ~scl_s & scl_d;
  wire start_det = scl_s & scl_d & ~sda_s & sda_d;
  wire stop_det  = scl_s & scl_d & sda_s & ~sda_d;

  assign scl_oe    = stretch;
  assign sda_oe    = ack_drv | ((st == S_TX) & ~tsr[7]);
  assign buf_rdata = buf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_sy   <= 2'b11;
      sda_sy   <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
      bitcnt   <= '0;
      sr       <= '0;
      tsr      <= 8'hFF;
      buf_q    <= '0;
      ack_drv  <= 1'b0;
      stretch  <= 1'b0;
      wr_done  <= 1'b0;
      irq      <= 1'b0;
      buf_full <= 1'b0;
      ovf      <= 1'b0;
      rw_flag  <= 1'b0;
      rel      <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
      if (irq_clr) irq <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      if (buf_rd)  buf_full <= 1'b0;

      if (start_det || stop_det) begin
        st      <= start_det ? S_ADDR : S_IDLE;
        bitcnt  <= '0;
        ack_drv <= 1'b0;
        stretch <= 1'b0;
        tsr     <= 8'hFF;
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) sr <= {sr[6:0], sda_s};
          if (bitcnt == 4'd8 && st == S_TX && sda_s) begin
            st       <= S_IDLE;
            rw_flag  <= 1'b0;
            buf_full <= 1'b0;
          end
          bitcnt <= bitcnt + 4'd1;
        end
        if (scl_fall) begin
          if (st == S_TX && bitcnt >= 4'd1 && bitcnt <= 4'd8)
            tsr <= {tsr[6:0], 1'b1};
          if (bitcnt == 4'd8 && st != S_TX) begin
            if (st == S_ADDR && sr[7:1] != DEV_ADDR) begin
              st <= S_IDLE;
            end else if (buf_full || ovf) begin
              ovf <= ovf | buf_full;
              if (st == S_ADDR) st <= S_IDLE;
            end else begin
              ack_drv  <= 1'b1;
              buf_q    <= sr;
              buf_full <= 1'b1;
              if (st == S_ADDR) begin
                rw_flag <= sr[0];
                st      <= sr[0] ? S_TX : S_RX;
              end
            end
          end
          if (bitcnt == 4'd9) begin
            ack_drv <= 1'b0;
            bitcnt  <= '0;
            irq     <= 1'b1;
            if (st == S_TX) begin
              stretch <= 1'b1;
              rel     <= 1'b0;
              wr_done <= 1'b0;
            end
          end
        end
      end

      if (buf_wr) begin
        buf_q   <= buf_wdata;
        tsr     <= buf_wdata;
        wr_done <= 1'b1;
      end
      if (rel_set && wr_done) begin
        rel     <= 1'b1;
        stretch <= 1'b0;
      end
    end
  end

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> (!sda_oe && !scl_oe));

  p_no_ack_when_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drv) |-> (!$past(buf_full) && !$past(ovf)));

  p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

  p_release_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stretch) && !$past(start_det || stop_det)) |-> $past(wr_done));

  p_sda_steady_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(buf_wr)) |-> $stable(sda_oe));

endmodule

// File: tb/i2c_stretch_slave_bench.sv
module i2c_stretch_slave_bench;
  localparam logic [6:0] A = 7'h2D;
  localparam int Q = 10;
  localparam int H = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic buf_wr = 1'b0, buf_rd = 1'b0, rel_set = 1'b0, irq_clr = 1'b0, ovf_clr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic scl_oe, sda_oe, irq, buf_full, ovf, rw_flag, rel;
  logic [7:0] buf_rdata;
  int total = 0, bad = 0;
  bit ended = 0;

  wire scl_bus = !(m_scl_low || scl_oe);
  wire sda_bus = !(m_sda_low || sda_oe);

  always #10 clk = ~clk;

  i2c_stretch_slave #(.DEV_ADDR(A)) u_i2c_stretch_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .buf_rd(buf_rd), .buf_rdata(buf_rdata), .rel_set(rel_set), .irq_clr(irq_clr),
    .ovf_clr(ovf_clr), .irq(irq), .buf_full(buf_full), .ovf(ovf),
    .rw_flag(rw_flag), .rel(rel));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wait_high();
    int n = 0;
    while (!scl_bus && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk("R8 SCL never released", 0, 1);
  endtask

  task automatic m_bit(input bit drv, output bit smp);
    repeat (Q) @(negedge clk);
    m_sda_low = drv;
    repeat (Q) @(negedge clk);
    m_scl_low = 1'b0;
    wait_high();
    repeat (H/2) @(negedge clk);
    smp = sda_bus;
    repeat (H/2) @(negedge clk);
    m_scl_low = 1'b1;
  endtask

  task automatic m_start();
    m_sda_low = 1'b0;
    repeat (Q) @(negedge clk);
    m_scl_low = 1'b0;
    wait_high();
    repeat (H) @(negedge clk);
    m_sda_low = 1'b1;
    repeat (H) @(negedge clk);
    m_scl_low = 1'b1;
    repeat (Q) @(negedge clk);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    repeat (Q) @(negedge clk);
    m_scl_low = 1'b0;
    wait_high();
    repeat (H) @(negedge clk);
    m_sda_low = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic m_send(input logic [7:0] b, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) m_bit(!b[i], s);
    m_bit(1'b0, s);
    ack = !s;
    repeat (6) @(negedge clk);
  endtask

  task automatic m_recv(input bit ack, output logic [7:0] d);
    bit s;
    for (int i = 7; i >= 0; i--) begin m_bit(1'b0, s); d[i] = s; end
    m_bit(ack, s);
  endtask

  task automatic h_rd();     @(negedge clk) buf_rd = 1;  @(negedge clk) buf_rd = 0;  endtask
  task automatic h_irqclr(); @(negedge clk) irq_clr = 1; @(negedge clk) irq_clr = 0; endtask
  task automatic h_ovfclr(); @(negedge clk) ovf_clr = 1; @(negedge clk) ovf_clr = 0; endtask
  task automatic h_rel();    @(negedge clk) rel_set = 1; @(negedge clk) rel_set = 0; endtask
  task automatic h_wr(input logic [7:0] d);
    @(negedge clk) begin buf_wr = 1; buf_wdata = d; end
    @(negedge clk) buf_wr = 0;
  endtask

  task automatic t_reset();
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 flags", {irq, buf_full, ovf, rw_flag}, 0);
    chk("R1 rel", rel, 1);
  endtask

  task automatic t_write();
    bit ack;
    m_start();
    m_send({A, 1'b0}, ack);
    chk("R2 address ack", ack, 1);
    chk("R2 buffer holds address", buf_rdata, {A, 1'b0});
    chk("R2 rw_flag", rw_flag, 0);
    chk("R2 full set", buf_full, 1);
    chk("R6 irq after address", irq, 1);
    h_rd();
    chk("R4 read clears full", buf_full, 0);
    h_irqclr();
    chk("R6 irq cleared", irq, 0);
    m_send(8'hA5, ack);
    chk("R4 data ack", ack, 1);
    chk("R4 data stored", buf_rdata, 8'hA5);
    chk("R4 full set", buf_full, 1);
    chk("R6 irq after data", irq, 1);
    m_send(8'h3C, ack);
    chk("R5 nack when full", ack, 0);
    chk("R5 overflow set", ovf, 1);
    chk("R5 buffer kept", buf_rdata, 8'hA5);
    h_rd();
    m_send(8'h11, ack);
    chk("R5 nack when overflow set", ack, 0);
    chk("R5 buffer kept after ovf", buf_rdata, 8'hA5);
    chk("R5 full stays clear", buf_full, 0);
    m_stop();
    h_ovfclr();
    chk("R5 ovf_clr", ovf, 0);
    h_irqclr();
  endtask

  task automatic t_mismatch();
    bit ack;
    m_start();
    m_send({A ^ 7'h01, 1'b0}, ack);
    chk("R3 no ack on mismatch", ack, 0);
    chk("R3 no irq", irq, 0);
    chk("R3 no full", buf_full, 0);
    m_send({A, 1'b0}, ack);
    chk("R3 later byte ignored", ack, 0);
    chk("R3 buffer untouched", buf_rdata, 8'hA5);
    chk("R3 no stretch", scl_oe, 0);
    m_stop();
  endtask

  task automatic t_read();
    bit ack;
    logic [7:0] d;
    m_start();
    m_send({A, 1'b1}, ack);
    chk("R7 read address ack", ack, 1);
    chk("R7 rw_flag set", rw_flag, 1);
    h_irqclr();
    repeat (Q) @(negedge clk);
    m_scl_low = 1'b0;
    repeat (100) @(negedge clk);
    chk("R7 SCL held low", scl_bus, 0);
    chk("R7 rel cleared", rel, 0);
    h_rel();
    repeat (20) @(negedge clk);
    chk("R8 release before write ignored", scl_bus, 0);
    h_wr(8'hC3);
    repeat (20) @(negedge clk);
    chk("R8 write alone keeps stretch", scl_bus, 0);
    h_rel();
    repeat (10) @(negedge clk);
    chk("R8 SCL released", scl_bus, 1);
    chk("R8 rel set", rel, 1);
    m_recv(1'b1, d);
    chk("R9 first byte", d, 8'hC3);
    repeat (Q) @(negedge clk);
    m_sda_low = 1'b0;
    m_scl_low = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10 stretch after master ack", scl_bus, 0);
    chk("R10 irq after sent byte", irq, 1);
    h_irqclr();
    h_wr(8'h5A);
    h_rel();
    m_recv(1'b0, d);
    chk("R10 second byte", d, 8'h5A);
    repeat (6) @(negedge clk);
    chk("R11 rw cleared on nack", rw_flag, 0);
    chk("R11 full cleared on nack", buf_full, 0);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
    m_send({A, 1'b0}, ack);
    chk("R11 ignored until START", ack, 0);
    chk("R11 no irq", irq, 0);
    m_stop();
  endtask

  task automatic t_stop_abort();
    bit ack, s;
    m_start();
    m_send({A, 1'b0}, ack);
    chk("R12 setup ack", ack, 1);
    h_rd();
    h_irqclr();
    m_bit(1'b0, s);
    m_bit(1'b1, s);
    m_bit(1'b1, s);
    m_stop();
    chk("R12 lines released", {scl_oe, sda_oe}, 0);
    chk("R12 no byte stored", buf_full, 0);
    m_scl_low = 1'b1;
    repeat (Q) @(negedge clk);
    m_send({A, 1'b0}, ack);
    chk("R12 no ack without START", ack, 0);
    m_start();
    m_send({A, 1'b0}, ack);
    h_rd();
    m_send(8'h77, ack);
    chk("R12 fresh transfer ack", ack, 1);
    chk("R12 fresh data", buf_rdata, 8'h77);
    m_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_mismatch();
    t_read();
    t_stop_abort();
    finish_run();
  end
endmodule